// File: doc/BRIEF.md
# Glitch-free clock source and divider tap switcher

This block produces the core clock of a chip from one of several candidate clocks: a slow RC oscillator, a fast RC oscillator, and a set of binary divisions of a PLL output. The PLL output runs at sixteen times the crystal. It feeds a ripple divider in which each stage toggles through its own inverted output. That same inverted output clocks the next, slower stage. The lowest PLL settings are therefore taps of this chain, and the state of a slower tap at any moment is not known relative to a faster one.

Every change of source or tap goes through one mechanism, timed by a separate switching clock. The control first withdraws the enable of the running clock. It then waits until the withdrawal has been seen in the switching domain and lets a fixed number of switching-clock edges pass. Only after that does it grant the new clock. Each candidate clock resynchronises its own enable in its own domain. The rising half is taken on a rising edge and the enable is applied on a falling edge, so a gated clock only starts or stops while it is low. The core clock is the OR of all gated clocks. Requests arrive on a selection input that is synchronous to the switching clock. A busy flag shows that a change is in progress.

Top module: `clk_tap_switch`

## Requirements
- R1: Selection code 0 picks the slow RC clock, code 1 the fast RC clock, and code 2+k (k = 0 to TAPS-1) the PLL clock divided by 2^k. After a change completes, the core clock runs at the period of the chosen source.
- R2: After reset, the slow RC clock (code RESET_SEL, default 0) drives the core clock and busy is low.
- R3: At most one source is granted in the switching domain at any time.
- R4: During a change, the core clock stays low for at least SETTLE_CYC switching-clock periods between the last edge of the old clock and the first edge of the new one. The new clock is granted only after the old clock's enable has been seen low in the switching domain.
- R5: No high or low phase of the core clock is shorter than half a period of the fastest source (the undivided PLL clock).
- R6: Busy rises on the switching-clock edge that accepts a request. It stays high until the new source's enable has been seen high in the switching domain.
- R7: A request equal to the current selection is ignored: busy stays low and the core clock is unchanged.
- R8: A selection code of TAPS+2 or above is ignored: busy stays low and the core clock is unchanged.
- R9: A change of the selection input while busy does not disturb the change in flight. The new value is taken as a fresh request once the current change ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| swClk | input | 1 | Independent switching clock that times every change |
| slowClk | input | 1 | Slow RC oscillator clock |
| fastClk | input | 1 | Fast RC oscillator clock |
| pllClk | input | 1 | PLL output clock, input to the ripple divider |
| reqSel | input | SELW | Requested source code, synchronous to swClk |
| coreClk | output | 1 | Glitch-free core clock |
| busy | output | 1 | A change of source is in progress |

## Verification
The bench builds the block with its defaults: four PLL taps, a settle wait of four switching-clock edges, and reset onto the slow RC clock. With these values there are six legal codes and two illegal ones (6 and 7). The clock periods are chosen so that the switching clock is unrelated to every source. Moves from fast to slow taps, slow to fast taps, PLL to RC and RC to PLL can therefore be measured edge by edge on the core clock, with a runt monitor that runs through every transition.

// File: rtl/clk_tap_pkg.sv
`timescale 1ns/1ps
package clk_tap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_SETTLE,
    ST_CONFIRM
  } swState_t;

  typedef struct packed {
    logic hold;   // withdraw every grant
    logic apply;  // grant the latched target
  } swStrobe_t;

endpackage

// File: rtl/clk_tap_divider.sv
`timescale 1ns/1ps
module clk_tap_divider #(
  parameter int TAPS = 4
) (
  input  logic            rst_n,
  input  logic            pllClk,
  output logic [TAPS-1:0] tap
);
  logic [TAPS-1:0] tapN;

  assign tap[0]  = pllClk;
  assign tapN    = ~tap;

  generate
    for (genvar k = 1; k < TAPS; k++) begin : g_stage
      logic q;
      // stage clocked by inverted output of the faster stage
      always_ff @(posedge tapN[k-1] or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ~q;
      end
      assign tap[k] = q;
    end
  endgenerate
endmodule

// File: rtl/clk_tap_gate.sv
`timescale 1ns/1ps
module clk_tap_gate (
  input  logic rst_n,
  input  logic srcClk,
  input  logic enReq,
  output logic gclk,
  output logic enOut
);
  logic enMeta;

  always_ff @(posedge srcClk or negedge rst_n) begin
    if (!rst_n) enMeta <= 1'b0;
    else        enMeta <= enReq;
  end

  // enable changes only while the source is low
  always_ff @(negedge srcClk or negedge rst_n) begin
    if (!rst_n) enOut <= 1'b0;
    else        enOut <= enMeta;
  end

  assign gclk = srcClk & enOut;
endmodule

// File: rtl/clk_tap_datapath.sv
`timescale 1ns/1ps
module clk_tap_datapath
  import clk_tap_pkg::*;
#(
  parameter int TAPS      = 4,
  parameter int RESET_SEL = 0,
  localparam int NSRC     = TAPS + 2,
  localparam int SELW     = $clog2(NSRC)
) (
  input  logic            rst_n,
  input  logic            swClk,
  input  logic            slowClk,
  input  logic            fastClk,
  input  logic            pllClk,
  input  swStrobe_t       strobe,
  input  logic [SELW-1:0] target,
  output logic            coreClk,
  output logic            ackAny
);
  logic [TAPS-1:0] tap;
  logic [NSRC-1:0] srcClk;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] gclk;
  logic [NSRC-1:0] enOut;
  logic [NSRC-1:0] ackMeta;
  logic [NSRC-1:0] ackSync;

  clk_tap_divider #(.TAPS(TAPS)) u_div (
    .rst_n (rst_n),
    .pllClk(pllClk),
    .tap   (tap)
  );

  assign srcClk = {tap, fastClk, slowClk};

  always_ff @(posedge swClk or negedge rst_n) begin
    if (!rst_n)            grant <= NSRC'(1) << RESET_SEL;
    else if (strobe.hold)  grant <= '0;
    else if (strobe.apply) grant <= NSRC'(1) << target;
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      clk_tap_gate u_gate (
        .rst_n (rst_n),
        .srcClk(srcClk[i]),
        .enReq (grant[i]),
        .gclk  (gclk[i]),
        .enOut (enOut[i])
      );
    end
  endgenerate

  always_ff @(posedge swClk or negedge rst_n) begin
    if (!rst_n) begin
      ackMeta <= '0;
      ackSync <= '0;
    end else begin
      ackMeta <= enOut;
      ackSync <= ackMeta;
    end
  end

  assign ackAny  = |ackSync;
  assign coreClk = |gclk;

  // R3: never more than one grant
  a_r3_one_grant: assert property (@(posedge swClk) disable iff (!rst_n)
    $onehot0(grant));

  // R4: a hold strobe clears every grant
  a_r4_hold_clears: assert property (@(posedge swClk) disable iff (!rst_n)
    strobe.hold |=> (grant == '0));

  // R1: an apply strobe leaves exactly the target granted
  a_r1_apply_target: assert property (@(posedge swClk) disable iff (!rst_n)
    strobe.apply |=> (grant == (NSRC'(1) << $past(target))));
endmodule

// File: rtl/clk_tap_ctrl.sv
`timescale 1ns/1ps
module clk_tap_ctrl
  import clk_tap_pkg::*;
#(
  parameter int TAPS       = 4,
  parameter int SETTLE_CYC = 4,
  parameter int RESET_SEL  = 0,
  localparam int NSRC      = TAPS + 2,
  localparam int SELW      = $clog2(NSRC),
  localparam int CNTW      = $clog2(SETTLE_CYC + 1)
) (
  input  logic            rst_n,
  input  logic            swClk,
  input  logic [SELW-1:0] reqSel,
  input  logic            ackAny,
  output swStrobe_t       strobe,
  output logic [SELW-1:0] target,
  output logic            busy
);
  swState_t        state;
  logic [SELW-1:0] curSel;
  logic [CNTW-1:0] cnt;
  logic            reqValid;
  logic            accept;
  logic            settleDone;

  assign reqValid   = ({1'b0, reqSel} < (SELW + 1)'(NSRC));
  assign accept     = ackAny && reqValid && (reqSel != curSel);
  assign settleDone = (cnt == CNTW'(SETTLE_CYC - 1));

  always_comb begin
    strobe       = '0;
    strobe.hold  = (state == ST_IDLE) && accept;
    strobe.apply = (state == ST_SETTLE) && settleDone;
  end

  always_ff @(posedge swClk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      curSel <= SELW'(RESET_SEL);
      target <= SELW'(RESET_SEL);
      cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          target <= reqSel;
          state  <= ST_DRAIN;
        end
        ST_DRAIN: if (!ackAny) begin
          cnt   <= '0;
          state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          cnt <= cnt + CNTW'(1);
          if (settleDone) begin
            curSel <= target;
            state  <= ST_CONFIRM;
          end
        end
        default: if (ackAny) state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R4: the new grant follows an observed idle acknowledge
  a_r4_apply_after_drain: assert property (@(posedge swClk) disable iff (!rst_n)
    strobe.apply |-> !ackAny);

  // R6: busy only falls once the new enable is seen
  a_r6_busy_until_ack: assert property (@(posedge swClk) disable iff (!rst_n)
    $fell(busy) |-> $past(ackAny));

  // R8: only legal codes start a change
  a_r8_valid_accept: assert property (@(posedge swClk) disable iff (!rst_n)
    $rose(busy) |-> ({1'b0, $past(reqSel)} < (SELW + 1)'(NSRC)));

  // R7: a request equal to the current code starts nothing
  a_r7_same_ignored: assert property (@(posedge swClk) disable iff (!rst_n)
    (!busy && reqSel == curSel) |=> !busy);
endmodule

// File: rtl/clk_tap_switch.sv
`timescale 1ns/1ps
module clk_tap_switch
  import clk_tap_pkg::*;
#(
  parameter int TAPS       = 4,
  parameter int SETTLE_CYC = 4,
  parameter int RESET_SEL  = 0,
  localparam int NSRC      = TAPS + 2,
  localparam int SELW      = $clog2(NSRC)
) (
  input  logic            rst_n,
  input  logic            swClk,
  input  logic            slowClk,
  input  logic            fastClk,
  input  logic            pllClk,
  input  logic [SELW-1:0] reqSel,
  output logic            coreClk,
  output logic            busy
);
  swStrobe_t       strobe;
  logic [SELW-1:0] target;
  logic            ackAny;

  clk_tap_ctrl #(
    .TAPS(TAPS), .SETTLE_CYC(SETTLE_CYC), .RESET_SEL(RESET_SEL)
  ) u_ctrl (
    .rst_n (rst_n),
    .swClk (swClk),
    .reqSel(reqSel),
    .ackAny(ackAny),
    .strobe(strobe),
    .target(target),
    .busy  (busy)
  );

  clk_tap_datapath #(
    .TAPS(TAPS), .RESET_SEL(RESET_SEL)
  ) u_dp (
    .rst_n  (rst_n),
    .swClk  (swClk),
    .slowClk(slowClk),
    .fastClk(fastClk),
    .pllClk (pllClk),
    .strobe (strobe),
    .target (target),
    .coreClk(coreClk),
    .ackAny (ackAny)
  );
endmodule

// File: tb/clk_tap_switch_tb.sv
`timescale 1ns/1ps
module clk_tap_switch_tb;
  localparam int  TAPS       = 4;
  localparam int  SETTLE_CYC = 4;
  localparam int  SELW       = 3;
  localparam real SW_PER     = 10.0;
  localparam real PLL_PER    = 4.0;
  localparam real FAST_PER   = 14.0;
  localparam real SLOW_PER   = 46.0;

  logic rst_n = 1'b0;
  logic swClk = 1'b0, slowClk = 1'b0, fastClk = 1'b0, pllClk = 1'b0;
  logic [SELW-1:0] reqSel = '0;
  logic coreClk, busy;

  int checks = 0, fails = 0, busyRises = 0, runts = 0;
  bit monOn = 0, haveEdge = 0, done = 0;
  realtime lastEdge = 0, lastFall = 0, maxLow = 0;

  always #(PLL_PER / 2)  pllClk  = ~pllClk;
  always #(FAST_PER / 2) fastClk = ~fastClk;
  always #(SLOW_PER / 2) slowClk = ~slowClk;
  always #(SW_PER / 2)   swClk   = ~swClk;

  clk_tap_switch u_dut (
    .rst_n(rst_n), .swClk(swClk), .slowClk(slowClk), .fastClk(fastClk),
    .pllClk(pllClk), .reqSel(reqSel), .coreClk(coreClk), .busy(busy)
  );

  // R5 monitor: every phase of the core clock
  always @(coreClk) begin
    if (monOn) begin
      if (haveEdge && ($realtime - lastEdge) < PLL_PER / 2 - 0.01) runts++;
      if (coreClk && haveEdge && ($realtime - lastFall) > maxLow)
        maxLow = $realtime - lastFall;
      if (!coreClk) lastFall = $realtime;
      lastEdge = $realtime;
      haveEdge = 1;
    end
  end

  always @(posedge busy) busyRises++;

  function automatic real expPeriod(int sel);
    if (sel == 0) return SLOW_PER;
    if (sel == 1) return FAST_PER;
    return PLL_PER * real'(1 << (sel - 2));
  endfunction

  task automatic check(string req, real act, real exp, real tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic measurePeriod(output real per);
    realtime t0;
    @(posedge coreClk); t0 = $realtime;
    @(posedge coreClk); per = $realtime - t0;
  endtask

  task automatic waitBusyLow(output int cyc);
    cyc = 0;
    while (busy && cyc < 400) begin
      @(negedge swClk); cyc++;
    end
  endtask

  task automatic test_reset();
    real per;
    check("R2 busy after reset", real'(busy), 0.0, 0.0);
    measurePeriod(per);
    check("R2 period after reset", per, SLOW_PER, 0.05);
  endtask

  // R1, R4, R6: one full change
  task automatic test_switch(int sel);
    real per;
    int  cyc;
    @(negedge swClk);
    maxLow = 0;
    reqSel = SELW'(sel);
    @(negedge swClk);
    check("R6 busy raised", real'(busy), 1.0, 0.0);
    waitBusyLow(cyc);
    check("R6 busy cleared in time", real'(cyc < 200), 1.0, 0.0);
    measurePeriod(per);
    check("R1 period of new source", per, expPeriod(sel), 0.05);
    check("R4 low gap covers settle", real'(maxLow >= SETTLE_CYC * SW_PER), 1.0, 0.0);
  endtask

  // R7 and R8: requests that must start nothing
  task automatic test_ignored(int sel, int curSel, string req);
    real per;
    @(negedge swClk);
    reqSel = SELW'(sel);
    for (int i = 0; i < 30; i++) begin
      @(negedge swClk);
      if (busy) begin
        check(req, 1.0, 0.0, 0.0);
        break;
      end
    end
    check(req, real'(busy), 0.0, 0.0);
    measurePeriod(per);
    check(req, per, expPeriod(curSel), 0.05);
    @(negedge swClk);
    reqSel = SELW'(curSel);
  endtask

  // R9: change the request while a change is in flight
  task automatic test_held();
    real per;
    int  cyc, quiet, rises0;
    @(negedge swClk);
    rises0 = busyRises;
    reqSel = SELW'(3);
    @(negedge swClk);
    check("R9 first change busy", real'(busy), 1.0, 0.0);
    reqSel = SELW'(1);
    quiet = 0; cyc = 0;
    while (quiet < 60 && cyc < 1000) begin
      @(negedge swClk); cyc++;
      quiet = busy ? 0 : quiet + 1;
    end
    check("R9 second change taken", real'(busyRises - rises0), 2.0, 0.0);
    measurePeriod(per);
    check("R9 final source", per, expPeriod(1), 0.05);
  endtask

  initial begin
    #(200_000 * 4.0);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge swClk);
    rst_n = 1'b1;
    repeat (40) @(negedge swClk);
    monOn = 1;
    test_reset();
    test_switch(2);                 // slow RC to undivided PLL
    test_switch(5);                 // fast tap to slow tap
    test_switch(3);                 // slow tap to faster tap
    test_switch(1);                 // PLL to fast RC
    test_ignored(1, 1, "R7 same code ignored");
    test_ignored(7, 1, "R8 illegal code ignored");
    test_ignored(6, 1, "R8 first illegal code ignored");
    test_switch(0);                 // fast RC to slow RC
    test_switch(4);                 // slow RC to PLL/4
    test_held();
    check("R5 no runt phases", real'(runts), 0.0, 0.0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule